// File: doc/BRIEF.md
# Compare-match GPIO port

An eight-pin general-purpose I/O port seen by software through a small word-addressed register bus. Each pin owns an output latch bit, a synchronised input bit and a three-bit mode code. The mode code chooses among high-impedance input, input with a pull-up request, open-drain, push-pull, and two alternate-function variants that take their data from a per-pin side input instead of the latch.

Interrupts use mismatch detection instead of edge logic. A pin is pending when its synchronised input differs from its compare bit and its mask bit is set. One registered line carries the OR of all pending pins. Software selects active-high sensing with a compare bit of 0 and active-low sensing with a compare bit of 1. Software can also copy the pin's present value into the compare bit to clear the mismatch, which gives edge detection.

The output, compare, mask and the three mode-code registers each have a plain address, a set alias and a clear alias. A write through an alias changes only the bits written as 1.

Top module: `gpio_cmp_port`

## Requirements
- R1: After reset every register reads 0, pad_oe and pull_up are all 0, and irq is 0.
- R2: For the output, mode-code, compare and mask registers, a write to the set alias (base+1) ORs wdata into the register. A write to the clear alias (base+2) clears the bits that are 1 in wdata. Bits written as 0 keep their value.
- R3: The registers can be written directly at their base address (output 0, mode bit0 4, mode bit1 7, mode bit2 10, compare 13, mask 16). A read returns the register on bus_rdata in the cycle after the request.
- R4: The input register (address 3) returns pin_in after a two-flop synchroniser, so a pin change is visible two clock edges later. Writes to address 3 have no effect.
- R5: irq is registered and equals the OR over pins of (synchronised input XOR compare) AND mask. It stays high while that condition holds. Writing the compare bit to the input value drops it one edge later.
- R6: The mode code of pin i is {bit i of mode-bit2, bit i of mode-bit1, bit i of mode-bit0}. Codes 000, 100 and 001 never drive the pad. Code 001 alone sets pull_up.
- R7: Codes 010 and 110 are open-drain from the output latch: pad_oe is the inverse of the latch bit and pad_out is 0.
- R8: Code 011 is push-pull: pad_oe is 1 and pad_out equals the latch bit.
- R9: Code 111 drives alt_data push-pull. Code 101 is open-drain from alt_data: pad_oe is the inverse of alt_data and pad_out is 0.
- R10: Set and clear aliases read as 0. Addresses above 18 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read |
| pin_in | input | 8 | Asynchronous pad inputs |
| alt_data | input | 8 | Alternate-function data per pin |
| pad_out | output | 8 | Pad drive value |
| pad_oe | output | 8 | Pad drive enable |
| pull_up | output | 8 | Weak pull-up request |
| irq | output | 1 | Port interrupt, level |

## Verification
The bus assertions assume that bus_addr, bus_write and bus_wdata are stable and known whenever bus_valid is high. The bench meets this by changing them only on falling edges, with one request per cycle.

The interrupt assertions assume that pin_in is steady for at least three edges before a result is judged. The stimulus changes pins only between checks and waits that many cycles. alt_data is assumed to change only while no alternate mode is being checked.

// File: rtl/gpcp_pkg.sv
package gpcp_pkg;

    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_OUT  = 5'd0;
    localparam logic [ADDR_W-1:0] A_IN   = 5'd3;
    localparam logic [ADDR_W-1:0] A_MD0  = 5'd4;
    localparam logic [ADDR_W-1:0] A_MD1  = 5'd7;
    localparam logic [ADDR_W-1:0] A_MD2  = 5'd10;
    localparam logic [ADDR_W-1:0] A_CMP  = 5'd13;
    localparam logic [ADDR_W-1:0] A_MSK  = 5'd16;
    localparam logic [ADDR_W-1:0] A_LAST = 5'd18;

    typedef enum logic [2:0] {
        MD_HIZ    = 3'b000,
        MD_PULLUP = 3'b001,
        MD_OD     = 3'b010,
        MD_PP     = 3'b011,
        MD_HIZ_B  = 3'b100,
        MD_ALT_OD = 3'b101,
        MD_OD_B   = 3'b110,
        MD_ALT_PP = 3'b111
    } pad_mode_t;

endpackage

// File: rtl/gpcp_sync.sv
module gpcp_sync #(
    parameter int NPIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] raw_i,
    output logic [NPIN-1:0] sync_o
);

    typedef struct packed {
        logic [NPIN-1:0] st1;
        logic [NPIN-1:0] st2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d     = sync_q;
        sync_d.st1 = raw_i;
        sync_d.st2 = sync_q.st1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_o = sync_q.st2;

endmodule

// File: rtl/gpcp_regs.sv
module gpcp_regs
    import gpcp_pkg::*;
#(
    parameter int NPIN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPIN-1:0]   bus_wdata,
    input  logic [NPIN-1:0]   in_sync,
    output logic [NPIN-1:0]   bus_rdata,
    output logic [NPIN-1:0]   out_q_o,
    output logic [NPIN-1:0]   md0_o,
    output logic [NPIN-1:0]   md1_o,
    output logic [NPIN-1:0]   md2_o,
    output logic [NPIN-1:0]   cmp_o,
    output logic [NPIN-1:0]   msk_o
);

    typedef struct packed {
        logic [NPIN-1:0] latch;
        logic [NPIN-1:0] md0;
        logic [NPIN-1:0] md1;
        logic [NPIN-1:0] md2;
        logic [NPIN-1:0] cmp;
        logic [NPIN-1:0] msk;
        logic [NPIN-1:0] rdata;
    } regs_t;

    regs_t regs_d, regs_q;

    // Direct / set / clear update for a register group starting at base
    function automatic logic [NPIN-1:0] grp_update(
        input logic [NPIN-1:0]   cur,
        input logic [NPIN-1:0]   wd,
        input logic [ADDR_W-1:0] addr,
        input logic [ADDR_W-1:0] base
    );
        logic [NPIN-1:0] res;
        res = cur;
        if (addr == base)                         res = wd;
        else if (addr == base + ADDR_W'(1))       res = cur | wd;
        else if (addr == base + ADDR_W'(2))       res = cur & ~wd;
        return res;
    endfunction

    logic wr_en, rd_en;
    assign wr_en = bus_valid &&  bus_write;
    assign rd_en = bus_valid && !bus_write;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            regs_d.latch = grp_update(regs_q.latch, bus_wdata, bus_addr, A_OUT);
            regs_d.md0   = grp_update(regs_q.md0,   bus_wdata, bus_addr, A_MD0);
            regs_d.md1   = grp_update(regs_q.md1,   bus_wdata, bus_addr, A_MD1);
            regs_d.md2   = grp_update(regs_q.md2,   bus_wdata, bus_addr, A_MD2);
            regs_d.cmp   = grp_update(regs_q.cmp,   bus_wdata, bus_addr, A_CMP);
            regs_d.msk   = grp_update(regs_q.msk,   bus_wdata, bus_addr, A_MSK);
        end
        if (rd_en) begin
            case (bus_addr)
                A_OUT:   regs_d.rdata = regs_q.latch;
                A_IN:    regs_d.rdata = in_sync;
                A_MD0:   regs_d.rdata = regs_q.md0;
                A_MD1:   regs_d.rdata = regs_q.md1;
                A_MD2:   regs_d.rdata = regs_q.md2;
                A_CMP:   regs_d.rdata = regs_q.cmp;
                A_MSK:   regs_d.rdata = regs_q.msk;
                default: regs_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign bus_rdata = regs_q.rdata;
    assign out_q_o   = regs_q.latch;
    assign md0_o     = regs_q.md0;
    assign md1_o     = regs_q.md1;
    assign md2_o     = regs_q.md2;
    assign cmp_o     = regs_q.cmp;
    assign msk_o     = regs_q.msk;

    AST_SET_ALIAS_OR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == A_OUT + ADDR_W'(1)) |=>
            (out_q_o == ($past(out_q_o) | $past(bus_wdata)))); // R2

    AST_CLR_ALIAS_AND: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == A_MSK + ADDR_W'(2)) |=>
            (msk_o == ($past(msk_o) & ~$past(bus_wdata)))); // R2

    AST_UNDEF_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr > A_LAST) |=>
            ($stable(out_q_o) && $stable(md0_o) && $stable(md1_o) &&
             $stable(md2_o) && $stable(cmp_o) && $stable(msk_o))); // R10

    AST_ALIAS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bus_addr == A_CMP + ADDR_W'(1)) |=> (bus_rdata == '0)); // R10

    AST_IN_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == A_IN) |=> $stable(out_q_o)); // R4

endmodule

// File: rtl/gpcp_pad.sv
module gpcp_pad
    import gpcp_pkg::*;
#(
    parameter int NPIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] latch_i,
    input  logic [NPIN-1:0] alt_i,
    input  logic [NPIN-1:0] md0_i,
    input  logic [NPIN-1:0] md1_i,
    input  logic [NPIN-1:0] md2_i,
    output logic [NPIN-1:0] pad_out_o,
    output logic [NPIN-1:0] pad_oe_o,
    output logic [NPIN-1:0] pull_up_o
);

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        pad_mode_t mode;
        assign mode = pad_mode_t'({md2_i[i], md1_i[i], md0_i[i]});

        always_comb begin
            pad_out_o[i] = 1'b0;
            pad_oe_o[i]  = 1'b0;
            pull_up_o[i] = 1'b0;
            case (mode)
                MD_PULLUP: pull_up_o[i] = 1'b1;
                MD_OD, MD_OD_B: pad_oe_o[i] = ~latch_i[i];
                MD_PP: begin
                    pad_oe_o[i]  = 1'b1;
                    pad_out_o[i] = latch_i[i];
                end
                MD_ALT_OD: pad_oe_o[i] = ~alt_i[i];
                MD_ALT_PP: begin
                    pad_oe_o[i]  = 1'b1;
                    pad_out_o[i] = alt_i[i];
                end
                default: ;
            endcase
        end

        AST_INPUT_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == MD_HIZ || mode == MD_HIZ_B || mode == MD_PULLUP) |->
                !pad_oe_o[i]); // R6

        AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == MD_OD || mode == MD_OD_B || mode == MD_ALT_OD) |->
                !pad_out_o[i]); // R7
    end

endmodule

// File: rtl/gpcp_irq.sv
module gpcp_irq #(
    parameter int NPIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] in_sync,
    input  logic [NPIN-1:0] cmp_i,
    input  logic [NPIN-1:0] msk_i,
    output logic            irq_o
);

    typedef struct packed {
        logic line;
    } irq_t;

    irq_t irq_d, irq_q;
    logic [NPIN-1:0] pending;

    always_comb begin
        pending    = (in_sync ^ cmp_i) & msk_i;
        irq_d      = irq_q;
        irq_d.line = |pending;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign irq_o = irq_q.line;

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (msk_i == '0) |=> !irq_o); // R5

    AST_MATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_sync & msk_i) == (cmp_i & msk_i)) |=> !irq_o); // R5

endmodule

// File: rtl/gpio_cmp_port.sv
module gpio_cmp_port
    import gpcp_pkg::*;
#(
    parameter int NPIN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPIN-1:0]   bus_wdata,
    output logic [NPIN-1:0]   bus_rdata,
    input  logic [NPIN-1:0]   pin_in,
    input  logic [NPIN-1:0]   alt_data,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe,
    output logic [NPIN-1:0]   pull_up,
    output logic              irq
);

    logic [NPIN-1:0] in_sync;
    logic [NPIN-1:0] latch, md0, md1, md2, cmp, msk;

    gpcp_sync #(.NPIN(NPIN)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pin_in),
        .sync_o (in_sync)
    );

    gpcp_regs #(.NPIN(NPIN)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .in_sync   (in_sync),
        .bus_rdata (bus_rdata),
        .out_q_o   (latch),
        .md0_o     (md0),
        .md1_o     (md1),
        .md2_o     (md2),
        .cmp_o     (cmp),
        .msk_o     (msk)
    );

    gpcp_pad #(.NPIN(NPIN)) i_pad (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_i   (latch),
        .alt_i     (alt_data),
        .md0_i     (md0),
        .md1_i     (md1),
        .md2_i     (md2),
        .pad_out_o (pad_out),
        .pad_oe_o  (pad_oe),
        .pull_up_o (pull_up)
    );

    gpcp_irq #(.NPIN(NPIN)) i_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_sync (in_sync),
        .cmp_i   (cmp),
        .msk_i   (msk),
        .irq_o   (irq)
    );

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq && pad_oe == '0)); // R1

endmodule

// File: tb/test_gpio_cmp_port.sv
module test_gpio_cmp_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_valid = 1'b0;
    logic       bus_write = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] alt_data = '0;
    logic [7:0] pad_out, pad_oe, pull_up;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];
    logic rd_seen = 1'b0;

    always #5 clk = ~clk;

    gpio_cmp_port i_gpio_cmp_port (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .alt_data(alt_data), .pad_out(pad_out), .pad_oe(pad_oe),
        .pull_up(pull_up), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: a read accepted on a rising edge is checked on the next falling edge
    always @(posedge clk) rd_seen <= bus_valid && !bus_write;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (sb.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard empty actual=%0h expected=none", bus_rdata);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [7:0] exp, input string tag);
        item_t it;
        it.exp = exp; it.tag = tag;
        sb.push_back(it);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 pull_up", pull_up, 8'h00);
        check("R1 irq", irq, 1'b0);
        for (int a = 0; a <= 18; a++) rd(5'(a), 8'h00, "R1 reg reset");

        // R3 direct write and readback
        wr(5'd0, 8'hA5);
        rd(5'd0, 8'hA5, "R3 out direct");
        // R2 set/clear on output latch
        wr(5'd1, 8'h0F);
        rd(5'd0, 8'hAF, "R2 out set");
        wr(5'd2, 8'hA0);
        rd(5'd0, 8'h0F, "R2 out clear");
        rd(5'd1, 8'h00, "R10 set alias reads 0");
        rd(5'd2, 8'h00, "R10 clear alias reads 0");
        // R3/R2 on compare and mask
        wr(5'd13, 8'h3C);
        rd(5'd13, 8'h3C, "R3 cmp direct");
        wr(5'd14, 8'h81);
        rd(5'd13, 8'hBD, "R2 cmp set");
        wr(5'd15, 8'h0C);
        rd(5'd13, 8'hB1, "R2 cmp clear");
        rd(5'd14, 8'h00, "R10 cmp alias reads 0");
        wr(5'd16, 8'h55);
        wr(5'd17, 8'h02);
        wr(5'd18, 8'h11);
        rd(5'd16, 8'h46, "R2 msk set/clear");
        wr(5'd13, 8'h00);
        wr(5'd16, 8'h00);
        cyc(1);

        // R8 push-pull: code 011
        wr(5'd4, 8'hFF); wr(5'd7, 8'hFF); wr(5'd10, 8'h00);
        rd(5'd7, 8'hFF, "R3 md1 direct");
        check("R8 pp oe", pad_oe, 8'hFF);
        check("R8 pp out", pad_out, 8'h0F);
        // R7 open-drain code 010
        wr(5'd6, 8'hFF);
        check("R7 od oe", pad_oe, 8'hF0);
        check("R7 od out", pad_out, 8'h00);
        // R7 code 110
        wr(5'd11, 8'hFF);
        check("R7 od110 oe", pad_oe, 8'hF0);
        check("R7 od110 out", pad_out, 8'h00);
        // R9 alt push-pull 111
        alt_data = 8'h3C;
        wr(5'd5, 8'hFF);
        check("R9 altpp oe", pad_oe, 8'hFF);
        check("R9 altpp out", pad_out, 8'h3C);
        // R9 alt open-drain 101
        wr(5'd9, 8'hFF);
        check("R9 altod oe", pad_oe, 8'hC3);
        check("R9 altod out", pad_out, 8'h00);
        // R6 input 100
        wr(5'd6, 8'hFF);
        check("R6 hiz100 oe", pad_oe, 8'h00);
        check("R6 hiz100 pull", pull_up, 8'h00);
        // R6 pull-up 001 on low nibble, 000 on high nibble
        wr(5'd10, 8'h00); wr(5'd4, 8'h0F);
        check("R6 pullup oe", pad_oe, 8'h00);
        check("R6 pullup flag", pull_up, 8'h0F);
        rd(5'd10, 8'h00, "R2 md2 clear");

        // R4 input path
        pin_in = 8'h5A;
        cyc(1);
        rd(5'd3, 8'h00, "R4 input not yet synced");
        cyc(2);
        rd(5'd3, 8'h5A, "R4 input synced");
        wr(5'd3, 8'hFF);
        rd(5'd3, 8'h5A, "R4 write to input ignored");
        rd(5'd0, 8'h0F, "R4 latch untouched by input write");

        // R5 interrupt
        wr(5'd13, 8'h00);
        cyc(2);
        check("R5 masked no irq", irq, 1'b0);
        wr(5'd17, 8'h02);     // unmask pin1, input high vs compare 0
        check("R5 irq not before register", irq, 1'b0);
        cyc(1);
        check("R5 irq asserts", irq, 1'b1);
        cyc(4);
        check("R5 irq held", irq, 1'b1);
        wr(5'd14, 8'h02);     // compare <- current value
        cyc(1);
        check("R5 irq cleared by compare", irq, 1'b0);
        pin_in = 8'h58;       // pin1 falls, compare 1: active-low mismatch
        cyc(2);
        check("R5 irq sync delay", irq, 1'b0);
        cyc(1);
        check("R5 irq low-level", irq, 1'b1);
        wr(5'd18, 8'h02);
        cyc(1);
        check("R5 irq mask clear", irq, 1'b0);
        wr(5'd17, 8'h80);     // pin7=0, cmp7=0: match
        cyc(2);
        check("R5 matched pin quiet", irq, 1'b0);

        // R10 undefined addresses
        wr(5'd20, 8'hFF);
        wr(5'd31, 8'hFF);
        rd(5'd0, 8'h0F, "R10 undef write out");
        rd(5'd13, 8'h02, "R10 undef write cmp");
        rd(5'd16, 8'h80, "R10 undef write msk");
        rd(5'd4, 8'h0F, "R10 undef write md0");
        rd(5'd20, 8'h00, "R10 undef read");
        cyc(3);
        check("R10 scoreboard drained", sb.size(), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule